// File: doc/BRIEF.md
# Dual Serial-Memory Port Multiplexer

This block connects two octal serial-memory controllers to two external pin ports. A configuration word picks one of four routings. In the direct and swapped routings each controller owns a port of its own. In the two shared routings both controllers reach a single port, and an arbiter hands that port to one controller at a time. A programmable idle gap is enforced between one owner's release and the next grant. Each controller's chip select can be steered to either of the two select lines on its port. Selects that meet on one line are combined as an AND of active-low signals.

The block also decodes a 256 MB memory-mapped window. A 3-bit split code divides the window between the two controllers. Each access is tagged with the controller that owns the address, and the address is rebased to the start of that controller's region. Addresses outside the window get an error response. Configuration writes are accepted only while both controllers are idle.

Top module: `sermem_port_mux`

## Requirements
- R1: Mode `00` routes controller 0 to port 0 and controller 1 to port 1. Mode `10` routes controller 0 to port 1 and controller 1 to port 0. In both modes the clock, data and output enable appear on the port one clock after the controller drives them, and `c_gnt` reads `11`.
- R2: Mode `01` shares port 0 and mode `11` shares port 1. The clock, data and output enable of the current grant holder appear on the shared port one clock later. While no controller holds the grant, the shared port's clock, data and enable are 0.
- R3: A port that no controller is routed to holds both select lines high, its clock low, and its output enable and data at 0.
- R4: In a shared mode the arbiter grants round-robin between pending requests, starting with controller 0 after reset. `c_gnt` is one-hot for the holder. A grant is kept until the holder has both its request low and its chip select high at a clock edge.
- R5: With gap value G, when a release is sampled at clock edge E, the next grant becomes visible exactly at edge E+G+1.
- R6: With the override disabled, controller 0's select drives line 0 (`p_ncs_n[p][0]`) and controller 1's select drives line 1 of the port it is routed to.
- R7: With the override enabled, bit i of the map field picks the line (0 or 1) that controller i's select drives.
- R8: When two controller selects reach the same line of the same port, that line is the AND of both active-low selects.
- R9: The split code gives controller 0 the lowest 256, 192, 128 or 64 MB for codes 0, 1, 2 and 3. Codes 4 to 7 give it nothing. The rest of the window belongs to controller 1. One clock after `mm_valid`, the response names the owner in `mm_rsp_ctl` (0 or 1) and gives the offset from that owner's region start.
- R10: An address whose bits above bit 27 differ from the window base returns `mm_rsp_err`=1, with `mm_rsp_ctl` and `mm_rsp_off` at 0.
- R11: The configuration word is laid out as mode [1:0], override enable [2], select map [4:3], split code [7:5] and gap [15:8]. A write while any controller has its select low or its request high leaves the word unchanged and sets `cfg_rej`. An accepted write takes effect at the next edge and clears `cfg_rej`.
- R12: After reset the configuration word and `cfg_rej` are 0, all port selects are high, port clocks and enables are 0, and `mm_rsp_valid` is 0.
- R13: A controller that currently drives a port sees that port's `p_dq_i` and `p_dqs` combinationally on `c_dq_i` and `c_dqs`. A controller that drives no port sees 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word |
| cfg_rej | output | 1 | Last write was refused because a controller was busy |
| c_req | input | 2 | Per-controller port request (shared modes) |
| c_gnt | output | 2 | Per-controller grant |
| c_sck | input | 2 | Controller serial clocks |
| c_cs_n | input | 2 | Controller chip selects, active low |
| c_dq_o | input | 2x8 | Controller output data |
| c_dq_oe | input | 2 | Controller data output enables |
| c_dq_i | output | 2x8 | Read data returned to each controller |
| c_dqs | output | 2 | Data strobe returned to each controller |
| p_sck | output | 2 | Port serial clocks |
| p_ncs_n | output | 2x2 | Two select lines per port, active low |
| p_dq_o | output | 2x8 | Port output data |
| p_dq_oe | output | 2 | Port data output enables |
| p_dq_i | input | 2x8 | Port input data |
| p_dqs | input | 2 | Port data strobes |
| mm_valid | input | 1 | Memory-mapped access valid |
| mm_addr | input | 32 | Memory-mapped address |
| mm_rsp_valid | output | 1 | Decode result valid |
| mm_rsp_err | output | 1 | Address outside the window |
| mm_rsp_ctl | output | 1 | Owning controller |
| mm_rsp_off | output | 28 | Offset within the owner's region |

## Verification
The routing sweep covers all four modes, with the override off and with each of the four map values. It drives all four select patterns and varying clock, data and enable values in each setting. This separates a wrong port choice, a wrong line choice and a missing AND of shared lines. Shared-mode runs use several gap values and both shared ports. They tell an early or late grant apart from a correct one and show round-robin alternation when both controllers request together. The split sweep goes through all eight codes. It probes every 16 MB step plus the last address below and the first address at each region boundary, and it probes addresses just outside both ends of the window.

// File: rtl/smx_pkg.sv
package smx_pkg;
  localparam int SMX_GAP_W = 8;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_SHARE_P0 = 2'b01,
    MODE_SWAP     = 2'b10,
    MODE_SHARE_P1 = 2'b11
  } smx_mode_e;

  typedef struct packed {
    logic [SMX_GAP_W-1:0] gap;
    logic [2:0]           split;
    logic [1:0]           cs_map;
    logic                 cs_ovr_en;
    smx_mode_e            mode;
  } smx_cfg_t;
endpackage

// File: rtl/smx_cfg_regs.sv
module smx_cfg_regs
  import smx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [$bits(smx_cfg_t)-1:0] wr_data,
  input  logic                   busy,
  output smx_cfg_t               cfg,
  output logic                   rej
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      rej <= 1'b0;
    end else if (wr_en) begin
      if (busy) begin
        rej <= 1'b1;
      end else begin
        cfg <= smx_cfg_t'(wr_data);
        rej <= 1'b0;
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) (wr_en && busy) |=> ($stable(cfg) && rej)); // R11
endmodule

// File: rtl/smx_arbiter.sv
module smx_arbiter
  import smx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shared,
  input  logic [1:0]           req,
  input  logic [1:0]           cs_n,
  input  logic [SMX_GAP_W-1:0] gap,
  output logic                 own_v,
  output logic                 own_id,
  output logic [1:0]           gnt
);
  logic [SMX_GAP_W-1:0] cnt;
  logic                 last;
  logic                 pick;

  assign pick = (req[0] && req[1]) ? ~last : req[1];

  always_ff @(posedge clk) begin
    if (rst || !shared) begin
      own_v  <= 1'b0;
      own_id <= 1'b0;
      cnt    <= '0;
      last   <= 1'b1;
    end else if (own_v) begin
      if (!req[own_id] && cs_n[own_id]) begin
        own_v <= 1'b0;
        cnt   <= gap;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (|req) begin
      own_v  <= 1'b1;
      own_id <= pick;
      last   <= pick;
    end
  end

  always_comb begin
    if (!shared)    gnt = 2'b11;
    else if (own_v) gnt = own_id ? 2'b10 : 2'b01;
    else            gnt = 2'b00;
  end

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst) (shared && !own_v && cnt != '0) |=> !own_v); // R5
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst) (shared && own_v && req[own_id]) |=> (own_v && own_id == $past(own_id))); // R4
endmodule

// File: rtl/smx_win_decode.sv
module smx_win_decode #(
  parameter int                ADDR_W   = 32,
  parameter int                WIN_BITS = 28,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2:0]          split,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic                rsp_ctl,
  output logic [WIN_BITS-1:0] rsp_off
);
  localparam int QB = WIN_BITS - 2;

  logic                in_win, to_c1;
  logic [WIN_BITS-1:0] off_in, base, rebased;
  logic [2:0]          c0_quarters;

  assign in_win      = addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];
  assign off_in      = addr[WIN_BITS-1:0];
  assign c0_quarters = split[2] ? 3'd0 : (3'd4 - {1'b0, split[1:0]});
  assign to_c1       = {1'b0, off_in[WIN_BITS-1:QB]} >= c0_quarters;
  assign base        = {c0_quarters[1:0], {QB{1'b0}}};
  assign rebased     = off_in - (to_c1 ? base : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_ctl   <= 1'b0;
      rsp_off   <= '0;
    end else begin
      rsp_valid <= valid;
      rsp_err   <= valid && !in_win;
      rsp_ctl   <= valid && in_win && to_c1;
      rsp_off   <= (valid && in_win) ? rebased : '0;
    end
  end

  AST_REBASE_LOW: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_err && !rsp_ctl) |-> rsp_off == $past(off_in)); // R9
endmodule

// File: rtl/sermem_port_mux.sv
module sermem_port_mux
  import smx_pkg::*;
#(
  parameter int                DQ_W     = 8,
  parameter int                ADDR_W   = 32,
  parameter int                WIN_BITS = 28,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [15:0]                cfg_wdata,
  output logic [15:0]                cfg_rdata,
  output logic                       cfg_rej,
  input  logic [1:0]                 c_req,
  output logic [1:0]                 c_gnt,
  input  logic [1:0]                 c_sck,
  input  logic [1:0]                 c_cs_n,
  input  logic [1:0][DQ_W-1:0]       c_dq_o,
  input  logic [1:0]                 c_dq_oe,
  output logic [1:0][DQ_W-1:0]       c_dq_i,
  output logic [1:0]                 c_dqs,
  output logic [1:0]                 p_sck,
  output logic [1:0][1:0]            p_ncs_n,
  output logic [1:0][DQ_W-1:0]       p_dq_o,
  output logic [1:0]                 p_dq_oe,
  input  logic [1:0][DQ_W-1:0]       p_dq_i,
  input  logic [1:0]                 p_dqs,
  input  logic                       mm_valid,
  input  logic [ADDR_W-1:0]          mm_addr,
  output logic                       mm_rsp_valid,
  output logic                       mm_rsp_err,
  output logic                       mm_rsp_ctl,
  output logic [WIN_BITS-1:0]        mm_rsp_off
);
  localparam int NCH = 2;

  smx_cfg_t cfg;
  logic     busy, shared, own_v, own_id;
  logic [NCH-1:0] port_of, line_of, drv;

  assign busy      = (|(~c_cs_n)) || (|c_req);
  assign shared    = cfg.mode[0];
  assign cfg_rdata = cfg;

  smx_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .busy(busy), .cfg(cfg), .rej(cfg_rej)
  );

  smx_arbiter u_arb (
    .clk(clk), .rst(rst), .shared(shared), .req(c_req), .cs_n(c_cs_n),
    .gap(cfg.gap), .own_v(own_v), .own_id(own_id), .gnt(c_gnt)
  );

  smx_win_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)) u_win (
    .clk(clk), .rst(rst), .valid(mm_valid), .addr(mm_addr), .split(cfg.split),
    .rsp_valid(mm_rsp_valid), .rsp_err(mm_rsp_err), .rsp_ctl(mm_rsp_ctl), .rsp_off(mm_rsp_off)
  );

  // Per-controller routing decisions
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      port_of[i] = shared ? cfg.mode[1] : (1'(i) ^ cfg.mode[1]);
      line_of[i] = cfg.cs_ovr_en ? cfg.cs_map[i] : 1'(i);
      drv[i]     = !shared || (own_v && (own_id == 1'(i)));
    end
  end

  // Next port values, then registered per port
  logic [NCH-1:0]            nx_sck, nx_oe;
  logic [NCH-1:0][1:0]       nx_ncs;
  logic [NCH-1:0][DQ_W-1:0]  nx_dq;

  always_comb begin
    nx_sck = '0;
    nx_oe  = '0;
    nx_ncs = '1;
    nx_dq  = '0;
    for (int p = 0; p < NCH; p++) begin
      for (int i = 0; i < NCH; i++) begin
        if (port_of[i] == 1'(p)) begin
          nx_ncs[p][line_of[i]] = nx_ncs[p][line_of[i]] & c_cs_n[i];
          if (drv[i]) begin
            nx_sck[p] = c_sck[i];
            nx_oe[p]  = c_dq_oe[i];
            nx_dq[p]  = c_dq_o[i];
          end
        end
      end
    end
  end

  for (genvar p = 0; p < NCH; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        p_sck[p]   <= 1'b0;
        p_ncs_n[p] <= 2'b11;
        p_dq_o[p]  <= '0;
        p_dq_oe[p] <= 1'b0;
      end else begin
        p_sck[p]   <= nx_sck[p];
        p_ncs_n[p] <= nx_ncs[p];
        p_dq_o[p]  <= nx_dq[p];
        p_dq_oe[p] <= nx_oe[p];
      end
    end
  end

  // Return path toward the controllers
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      c_dq_i[i] = drv[i] ? p_dq_i[port_of[i]] : '0;
      c_dqs[i]  = drv[i] & p_dqs[port_of[i]];
    end
  end

  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst) ($past(cfg.mode) == MODE_SHARE_P0) |-> (!p_sck[1] && !p_dq_oe[1] && p_ncs_n[1] == 2'b11)); // R3
  AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (rst) ($past(cfg.mode) == MODE_DIRECT) |-> (p_sck[0] == $past(c_sck[0]) && p_dq_o[0] == $past(c_dq_o[0]))); // R1
endmodule

// File: tb/sermem_port_mux_bench.sv
`timescale 1ns/1ps
module sermem_port_mux_bench;
  localparam logic [31:0] WB = 32'h9000_0000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [15:0]      cfg_wdata = '0;
  logic [15:0]      cfg_rdata;
  logic             cfg_rej;
  logic [1:0]       c_req = '0, c_gnt, c_sck = '0, c_cs_n = 2'b11, c_dq_oe = '0, c_dqs;
  logic [1:0][7:0]  c_dq_o = '0, c_dq_i;
  logic [1:0]       p_sck, p_dq_oe, p_dqs = '0;
  logic [1:0][1:0]  p_ncs_n;
  logic [1:0][7:0]  p_dq_o, p_dq_i = '0;
  logic             mm_valid = 1'b0;
  logic [31:0]      mm_addr = '0;
  logic             mm_rsp_valid, mm_rsp_err, mm_rsp_ctl;
  logic [27:0]      mm_rsp_off;

  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sermem_port_mux u_sermem_port_mux (.*);

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkcfg(input logic [1:0] m, input logic e, input logic [1:0] mp,
                                        input logic [2:0] sp, input logic [7:0] g);
    return {g, sp, mp, e, m};
  endfunction

  task automatic cfg_write(input logic [15:0] w);
    cfg_we = 1'b1; cfg_wdata = w; tick; cfg_we = 1'b0;
  endtask

  task automatic wait_gnt(output int n);
    n = 0;
    do begin tick; n++; end while (c_gnt == 2'b00 && n < 400);
  endtask

  task automatic shared_run(input logic [1:0] m, input logic [7:0] g);
    logic op; int n;
    op = m[1];
    c_cs_n = 2'b11; c_req = 2'b00; c_sck = '0; c_dq_oe = '0;
    cfg_write(mkcfg(m, 1'b0, 2'b00, 3'd0, g));
    chk("R11 accepted write", cfg_rdata, mkcfg(m, 1'b0, 2'b00, 3'd0, g));
    c_req = 2'b11; tick;
    chk("R4 first grant to controller 0", c_gnt, 2'b01);
    c_cs_n = 2'b10; c_sck = 2'b01; c_dq_o[0] = 8'h3C; c_dq_o[1] = 8'hC3; c_dq_oe = 2'b11;
    p_dq_i[op] = 8'h5A; p_dq_i[~op] = 8'hEE; p_dqs = 2'b11;
    #1;
    chk("R13 owner read data", c_dq_i[0], 8'h5A);
    chk("R13 non-owner read data", c_dq_i[1], 8'h00);
    chk("R13 strobes", c_dqs, 2'b01);
    tick;
    chk("R2 owner on shared port", {p_sck[op], p_dq_oe[op], p_dq_o[op]}, {1'b1, 1'b1, 8'h3C});
    chk("R6 shared port lines", p_ncs_n[op], 2'b10);
    chk("R3 unused port", {p_sck[~op], p_dq_oe[~op], p_dq_o[~op], p_ncs_n[~op]}, {1'b0, 1'b0, 8'h00, 2'b11});
    repeat (3) tick;
    chk("R4 grant held while requesting", c_gnt, 2'b01);
    c_req[0] = 1'b0; tick; tick;
    chk("R4 grant held while select low", c_gnt, 2'b01);
    c_cs_n[0] = 1'b1; c_sck = '0; c_dq_oe = '0;
    wait_gnt(n);
    chk("R5 gap edges", n, g + 2);
    chk("R4 grant passes to controller 1", c_gnt, 2'b10);
    c_req[0] = 1'b1; c_cs_n[1] = 1'b0; c_sck = 2'b10; c_dq_o[1] = 8'h96; c_dq_oe = 2'b10; tick; tick;
    chk("R2 second owner data", {p_sck[op], p_dq_oe[op], p_dq_o[op]}, {1'b1, 1'b1, 8'h96});
    chk("R4 waiting requester not granted", c_gnt, 2'b10);
    c_req[1] = 1'b0; c_cs_n[1] = 1'b1; c_sck = '0; c_dq_oe = '0; tick;
    c_req[1] = 1'b1;
    wait_gnt(n);
    chk("R4 round-robin picks controller 0", c_gnt, 2'b01);
    c_req[0] = 1'b0; tick;
    c_req[0] = 1'b1;
    wait_gnt(n);
    chk("R4 round-robin picks controller 1", c_gnt, 2'b10);
    c_req = 2'b00; c_cs_n = 2'b11;
    repeat (g + 4) tick;
  endtask

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    chk("R12 reset ports", {p_sck, p_dq_oe, p_ncs_n}, {2'b00, 2'b00, 4'hF});
    chk("R12 reset config", {cfg_rdata, cfg_rej, mm_rsp_valid}, 18'h0);

    // Routing sweep
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int mp = 0; mp < 4; mp++) begin
          if (e == 0 && mp != 0) continue;
          c_cs_n = 2'b11; c_req = 2'b00;
          cfg_write(mkcfg(2'(m), 1'(e), 2'(mp), 3'd0, 8'd0));
          chk("R11 accepted write", cfg_rdata, mkcfg(2'(m), 1'(e), 2'(mp), 3'd0, 8'd0));
          for (int k = 0; k < 16; k++) begin
            logic [1:0][1:0] en;
            logic [1:0] pt, ln;
            c_cs_n = 2'(k); c_sck = {k[2], ~k[2]}; c_dq_oe = 2'(k >> 2);
            c_dq_o[0] = 8'(8'h11 * k); c_dq_o[1] = ~8'(8'h11 * k);
            p_dq_i[0] = 8'hC0 | 8'(k); p_dq_i[1] = 8'h30 | 8'(k); p_dqs = 2'(k) ^ 2'b10;
            en = '1;
            for (int i = 0; i < 2; i++) begin
              pt[i] = m[0] ? m[1] : (i[0] ^ m[1]);
              ln[i] = e[0] ? mp[i] : i[0];
              en[pt[i]][ln[i]] = en[pt[i]][ln[i]] & c_cs_n[i];
            end
            #1;
            for (int i = 0; i < 2; i++)
              chk("R13 return data", {c_dq_i[i], c_dqs[i]},
                  m[0] ? 9'h0 : {p_dq_i[pt[i]], p_dqs[pt[i]]});
            tick;
            for (int p = 0; p < 2; p++) begin
              logic [9:0] ed;
              ed = 10'h0;
              for (int i = 0; i < 2; i++)
                if (!m[0] && pt[i] == 1'(p)) ed = {c_sck[i], c_dq_oe[i], c_dq_o[i]};
              chk(m[0] ? "R2 no owner idle data" : "R1 routed data", {p_sck[p], p_dq_oe[p], p_dq_o[p]}, ed);
              chk(e ? "R7 override lines" : "R6 default lines", p_ncs_n[p], en[p]);
              if (m[0] && p != int'(m[1]))
                chk("R3 unused port selects", {p_sck[p], p_dq_oe[p], p_ncs_n[p]}, 4'b0011);
            end
            if (m[0] && e && mp[0] == mp[1])
              chk("R8 AND of selects", p_ncs_n[m[1]][mp[0]], c_cs_n[0] & c_cs_n[1]);
            if (!m[0]) chk("R1 both granted", c_gnt, 2'b11);
          end
        end

    shared_run(2'b01, 8'd0);
    shared_run(2'b01, 8'd3);
    shared_run(2'b11, 8'd1);
    shared_run(2'b11, 8'd7);

    // Busy rejection
    begin
      logic [15:0] cur;
      c_cs_n = 2'b11; c_req = 2'b00;
      cfg_write(mkcfg(2'b00, 1'b0, 2'b00, 3'd2, 8'd5));
      cur = cfg_rdata;
      c_cs_n = 2'b10;
      cfg_write(mkcfg(2'b10, 1'b1, 2'b11, 3'd6, 8'd9));
      chk("R11 busy select keeps config", cfg_rdata, cur);
      chk("R11 busy flag", cfg_rej, 1'b1);
      c_cs_n = 2'b11; c_req = 2'b10;
      cfg_write(mkcfg(2'b10, 1'b1, 2'b11, 3'd6, 8'd9));
      chk("R11 busy request keeps config", cfg_rdata, cur);
      c_req = 2'b00;
      cfg_write(mkcfg(2'b10, 1'b1, 2'b11, 3'd6, 8'd9));
      chk("R11 idle write applies", cfg_rdata, mkcfg(2'b10, 1'b1, 2'b11, 3'd6, 8'd9));
      chk("R11 flag cleared", cfg_rej, 1'b0);
    end

    // Window split sweep
    for (int code = 0; code < 8; code++) begin
      int c0q;
      c0q = (code >= 4) ? 0 : 4 - code;
      cfg_write(mkcfg(2'b00, 1'b0, 2'b00, 3'(code), 8'd0));
      for (int j = 0; j < 18; j++) begin
        logic [27:0] off, eoff;
        logic ectl;
        if (j < 16)       off = 28'(j * 32'h0100_0000 + j * 32'h777);
        else if (j == 16) off = 28'(c0q * 32'h0400_0000 - 1);
        else              off = 28'(c0q * 32'h0400_0000);
        ectl = int'(off[27:26]) >= c0q;
        eoff = ectl ? off - 28'(c0q * 32'h0400_0000) : off;
        mm_valid = 1'b1; mm_addr = WB | {4'h0, off};
        tick;
        chk("R9 split decode", {mm_rsp_valid, mm_rsp_err, mm_rsp_ctl, mm_rsp_off}, {1'b1, 1'b0, ectl, eoff});
      end
      mm_addr = WB - 1; tick;
      chk("R10 below window", {mm_rsp_valid, mm_rsp_err, mm_rsp_ctl, mm_rsp_off}, {3'b110, 28'h0});
      mm_addr = WB + 32'h1000_0000; tick;
      chk("R10 above window", {mm_rsp_valid, mm_rsp_err, mm_rsp_ctl, mm_rsp_off}, {3'b110, 28'h0});
      mm_valid = 1'b0; tick;
      chk("R9 no request no response", mm_rsp_valid, 1'b0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule